// File: doc/BRIEF.md
# ADC Command SPI Engine

This block is a byte-level SPI master for a serial delta-sigma converter. A request names one of four transaction kinds (plain command, register write, register read, conversion readback) together with an opcode, a 4-bit register address and a write byte. The engine frames the bytes, shifts them out MSB first and, for the read kinds, clocks 8 or 24 bits back from the converter's serial output.

All waits the converter imposes are generated here. These are the idle gap between adjacent bytes, the settle wait before readback and the hold-off after each command. The readback wait and the hold-off are counted in converter master-clock periods and converted to system clocks through parameters. Chip select goes low before the first clock edge and stays low through the whole transaction, including its hold-off. The next request is accepted only once chip select has been released.

A conversion readback is returned sign-extended to 32 bits. A register read is returned zero-extended. A `done_o` pulse marks the cycle the result is valid.

Top module: `adc_cmd_spi_engine`

## Requirements
- R1: SCLK is low whenever CS is high. DIN changes only in the cycle SCLK rises, and the converter takes it on the falling edge. Every byte goes out MSB first, and each transaction produces exactly 8 SCLK pulses per byte sent or received.
- R2: Within a byte, every SCLK high phase and every low phase lasts exactly SCLK_HALF system clocks.
- R3: Kind code 1 (register write) sends three bytes: {op[7:4], addr}, then 0x00, then the write byte. It returns rx_data 0.
- R4: Kind code 2 (register read) sends {op[7:4], addr} and then 0x00, and then receives one byte. rx_data holds that byte zero-extended to 32 bits.
- R5: Kind code 3 (conversion readback) sends the opcode unchanged and then receives 24 bits, most significant byte first. rx_data holds those bits sign-extended from bit 23.
- R6: From the last falling SCLK of the command part of a read to the first rising SCLK of the readback, exactly SCLK_HALF + 50*MCLK_DIV system clocks pass.
- R7: Between any other two adjacent bytes, falling-to-rising SCLK spacing is exactly SCLK_HALF + BYTE_GAP system clocks.
- R8: After the final falling SCLK, CS stays low for exactly SCLK_HALF + 24*MCLK_DIV system clocks when the opcode is 0x03, 0xFC or 0xFE. For any other opcode it stays low for exactly SCLK_HALF + 4*MCLK_DIV system clocks.
- R9: CS falls on the edge a request is accepted and stays low SCLK_HALF system clocks before the first rising SCLK. req_ready_o is low from acceptance until CS rises, and an asynchronous reset returns CS high, SCLK low and ready high at once.
- R10: done_o is a one-cycle pulse issued on the edge CS rises, with rx_data_o valid. Kind code 0 (command only) sends just the opcode and returns rx_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_kind_i | input | 2 | 0 command, 1 register write, 2 register read, 3 readback |
| req_op_i | input | 8 | Opcode; high nibble used for register kinds |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 8 | Register write data |
| done_o | output | 1 | Transaction complete pulse |
| rx_data_o | output | 32 | Extended received data |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| din_o | output | 1 | Serial data to converter |
| dout_i | input | 1 | Serial data from converter |

## Verification
The bench targets the readback sign boundary with codes 0x800001, 0x7FFFFF and zero, and a register read of 0xFF. A design that extended the wrong way would return 0x007FFFFF-style positives for negative codes or smear ones into a register byte. It measures every SCLK phase and every byte boundary in cycles. This separates the long readback wait from the short inter-byte gap, so a design that used one where the other belongs shows a spacing mismatch. Hold-off is checked on the three long opcodes and on their near neighbours 0x00, 0xFD and 0xF0, which catches a loose opcode decode. A register write with opcode 0x5C checks that the address replaces the low nibble rather than being ORed into it. A reset in the middle of a readback checks that CS and SCLK return to idle at once.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_WREG  = 2'd1,
    KIND_RREG  = 2'd2,
    KIND_RDATA = 2'd3
  } req_kind_e;

  localparam int unsigned RDBK_WAIT_MCLK  = 50;
  localparam int unsigned HOLD_SHORT_MCLK = 4;
  localparam int unsigned HOLD_LONG_MCLK  = 24;

  function automatic logic [2:0] tx_count(input req_kind_e k);
    case (k)
      KIND_WREG: return 3'd3;
      KIND_RREG: return 3'd2;
      default:   return 3'd1;
    endcase
  endfunction

  function automatic logic [2:0] rx_count(input req_kind_e k);
    case (k)
      KIND_RREG:  return 3'd1;
      KIND_RDATA: return 3'd3;
      default:    return 3'd0;
    endcase
  endfunction

  // opcodes needing the long post-command hold-off
  function automatic logic long_hold(input logic [7:0] op);
    return (op == 8'h03) || (op == 8'hFC) || (op == 8'hFE);
  endfunction

endpackage

// File: rtl/adc_spi_gap_timer.sv
module adc_spi_gap_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/adc_spi_bit_shifter.sv
module adc_spi_bit_shifter #(
  parameter int unsigned SCLK_HALF = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_byte_i,
  input  logic       dout_i,
  output logic       sclk_o,
  output logic       din_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o
);
  localparam int unsigned HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [HW-1:0] HALF_M1 = HW'(SCLK_HALF - 1);

  logic          busy_q, sclk_q, din_q;
  logic [7:0]    sh_q, rx_q;
  logic [2:0]    bit_q;
  logic [HW-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      din_q  <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      hcnt_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b1;
        din_q  <= tx_byte_i[7];
        sh_q   <= {tx_byte_i[6:0], 1'b0};
        bit_q  <= '0;
        hcnt_q <= HALF_M1;
      end
    end else if (hcnt_q != '0) begin
      hcnt_q <= hcnt_q - 1'b1;
    end else if (sclk_q) begin
      // falling edge: converter takes DIN, we take DOUT
      sclk_q <= 1'b0;
      rx_q   <= {rx_q[6:0], dout_i};
      hcnt_q <= HALF_M1;
    end else if (bit_q == 3'd7) begin
      busy_q <= 1'b0;
    end else begin
      bit_q  <= bit_q + 1'b1;
      sclk_q <= 1'b1;
      din_q  <= sh_q[7];
      sh_q   <= {sh_q[6:0], 1'b0};
      hcnt_q <= HALF_M1;
    end
  end

  assign byte_done_o = busy_q && !sclk_q && (hcnt_q == '0) && (bit_q == 3'd7);
  assign sclk_o      = sclk_q;
  assign din_o       = din_q;
  assign rx_byte_o   = rx_q;
endmodule

// File: rtl/adc_cmd_spi_engine.sv
module adc_cmd_spi_engine
  import adc_spi_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 50,
  parameter int unsigned MCLK_DIV  = 33,
  parameter int unsigned BYTE_GAP  = 25
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [1:0]  req_kind_i,
  input  logic [7:0]  req_op_i,
  input  logic [3:0]  req_addr_i,
  input  logic [7:0]  req_wdata_i,
  output logic        done_o,
  output logic [31:0] rx_data_o,
  output logic        cs_no,
  output logic        sclk_o,
  output logic        din_o,
  input  logic        dout_i
);
  localparam int unsigned RDBK_CYC = RDBK_WAIT_MCLK * MCLK_DIV;
  localparam int unsigned HOLD_S   = HOLD_SHORT_MCLK * MCLK_DIV;
  localparam int unsigned HOLD_L   = HOLD_LONG_MCLK * MCLK_DIV;
  localparam int unsigned M1   = (RDBK_CYC > SCLK_HALF) ? RDBK_CYC : SCLK_HALF;
  localparam int unsigned TMAX = (M1 > BYTE_GAP) ? M1 : BYTE_GAP;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_BYTE, ST_GAP, ST_RDWAIT, ST_HOLD
  } state_e;

  state_e      state_q;
  req_kind_e   kind_q;
  logic [7:0]  op_q, wdata_q;
  logic [3:0]  addr_q;
  logic [2:0]  byte_q;
  logic [23:0] acc_q;
  logic        cs_q, done_q;
  logic [31:0] rx_data_q;

  logic          start, tmr_load, tmr_exp, byte_done;
  logic [TW-1:0] tmr_val;
  logic [7:0]    tx_next, rx_byte, first_byte;
  logic [2:0]    n_tx, n_all, next_idx;

  assign n_tx     = tx_count(kind_q);
  assign n_all    = n_tx + rx_count(kind_q);
  assign next_idx = byte_q + 3'd1;

  assign first_byte = (kind_q == KIND_WREG || kind_q == KIND_RREG) ?
                      {op_q[7:4], addr_q} : op_q;

  always_comb begin
    case (byte_q)
      3'd0:    tx_next = first_byte;
      3'd2:    tx_next = (kind_q == KIND_WREG) ? wdata_q : 8'h00;
      default: tx_next = 8'h00;
    endcase
  end

  always_comb begin
    start    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(SCLK_HALF - 1);
      end
      ST_LEAD, ST_GAP, ST_RDWAIT: start = tmr_exp;
      ST_BYTE: if (byte_done) begin
        tmr_load = 1'b1;
        if (next_idx == n_all)
          tmr_val = long_hold(op_q) ? TW'(HOLD_L - 1) : TW'(HOLD_S - 1);
        else if (next_idx == n_tx)
          tmr_val = TW'(RDBK_CYC - 1);
        else
          tmr_val = TW'(BYTE_GAP - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= KIND_CMD;
      op_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      byte_q    <= '0;
      acc_q     <= '0;
      cs_q      <= 1'b1;
      done_q    <= 1'b0;
      rx_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          kind_q  <= req_kind_e'(req_kind_i);
          op_q    <= req_op_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          byte_q  <= '0;
          acc_q   <= '0;
          cs_q    <= 1'b0;
          state_q <= ST_LEAD;
        end
        ST_LEAD, ST_GAP, ST_RDWAIT: if (tmr_exp) state_q <= ST_BYTE;
        ST_BYTE: if (byte_done) begin
          byte_q <= next_idx;
          if (byte_q >= n_tx) acc_q <= {acc_q[15:0], rx_byte};
          if (next_idx == n_all)     state_q <= ST_HOLD;
          else if (next_idx == n_tx) state_q <= ST_RDWAIT;
          else                       state_q <= ST_GAP;
        end
        ST_HOLD: if (tmr_exp) begin
          state_q <= ST_IDLE;
          cs_q    <= 1'b1;
          done_q  <= 1'b1;
          case (kind_q)
            KIND_RREG:  rx_data_q <= {24'h0, acc_q[7:0]};
            KIND_RDATA: rx_data_q <= {{8{acc_q[23]}}, acc_q};
            default:    rx_data_q <= '0;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  adc_spi_gap_timer #(.W(TW)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  adc_spi_bit_shifter #(.SCLK_HALF(SCLK_HALF)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .tx_byte_i   (tx_next),
    .dout_i      (dout_i),
    .sclk_o      (sclk_o),
    .din_o       (din_o),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign cs_no       = cs_q;
  assign done_o      = done_q;
  assign rx_data_o   = rx_data_q;
endmodule

// File: rtl/adc_cmd_spi_engine_chk.sv
module adc_cmd_spi_engine_chk #(
  parameter int unsigned SCLK_HALF = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic done_o,
  input logic cs_no,
  input logic sclk_o,
  input logic din_o
);
  localparam int unsigned CW = $clog2(SCLK_HALF + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] hi_cnt_q, lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
    end else if (sclk_o) begin
      lo_cnt_q <= '0;
      if (hi_cnt_q != CMAX) hi_cnt_q <= hi_cnt_q + 1'b1;
    end else begin
      hi_cnt_q <= '0;
      if (lo_cnt_q != CMAX) lo_cnt_q <= lo_cnt_q + 1'b1;
    end
  end

  p_sclk_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_din_on_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(sclk_o) |-> $stable(din_o));

  p_high_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> hi_cnt_q >= CW'(SCLK_HALF));

  p_low_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> lo_cnt_q >= CW'(SCLK_HALF));

  p_ready_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_no);

  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !cs_no));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o && $rose(cs_no)));
endmodule

bind adc_cmd_spi_engine adc_cmd_spi_engine_chk #(.SCLK_HALF(SCLK_HALF)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .cs_no       (cs_no),
  .sclk_o      (sclk_o),
  .din_o       (din_o)
);

// File: tb/test_adc_cmd_spi_engine.sv
`timescale 1ns/1ps
module test_adc_cmd_spi_engine;
  localparam int SH = 3;
  localparam int MD = 2;
  localparam int GP = 5;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_op = '0;
  logic [3:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        dout = 1'b0;
  logic        req_ready, done, cs_n, sclk, din;
  logic [31:0] rx_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  adc_cmd_spi_engine #(.SCLK_HALF(SH), .MCLK_DIV(MD), .BYTE_GAP(GP)) i_adc_cmd_spi_engine (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .done_o(done), .rx_data_o(rx_data),
    .cs_no(cs_n), .sclk_o(sclk), .din_o(din), .dout_i(dout)
  );

  // kind, op, addr, wdata, converter reply, expected rx_data
  localparam logic [77:0] VEC [NV] = '{
    {2'd3, 8'h01, 4'h0, 8'h00, 24'h800001, 32'hFF800001},
    {2'd3, 8'h01, 4'h0, 8'h00, 24'h7FFFFF, 32'h007FFFFF},
    {2'd3, 8'h01, 4'h0, 8'h00, 24'h000000, 32'h00000000},
    {2'd1, 8'h5C, 4'h3, 8'hA7, 24'h000000, 32'h00000000},
    {2'd1, 8'h50, 4'hF, 8'h00, 24'hFFFFFF, 32'h00000000},
    {2'd2, 8'h10, 4'h1, 8'h00, 24'hA53C00, 32'h000000A5},
    {2'd2, 8'h10, 4'h2, 8'h00, 24'hFF0000, 32'h000000FF},
    {2'd0, 8'hFC, 4'h0, 8'h00, 24'h000000, 32'h00000000},
    {2'd0, 8'hFE, 4'h0, 8'h00, 24'h000000, 32'h00000000},
    {2'd0, 8'h03, 4'h0, 8'h00, 24'h000000, 32'h00000000},
    {2'd0, 8'h00, 4'h0, 8'h00, 24'h000000, 32'h00000000},
    {2'd0, 8'hFD, 4'h0, 8'h00, 24'h000000, 32'h00000000},
    {2'd0, 8'hF0, 4'h0, 8'h00, 24'h000000, 32'h00000000}
  };

  // pin monitor, all times in clock cycles
  int         cyc = 0, nr = 0, nf = 0, t_csf = 0, t_csr = 0;
  int         rise_t [40];
  int         fall_t [40];
  logic [7:0] mosi [5];
  logic [23:0] miso_sr = '0, miso_load = '0;
  int         rx_start = 0;
  logic       prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_cs && !cs_n) begin
      t_csf = cyc; nr = 0; nf = 0; miso_sr = miso_load;
      for (int k = 0; k < 5; k++) mosi[k] = 8'h00;
    end
    if (!prev_cs && cs_n) t_csr = cyc;
    if (!prev_sclk && sclk && nr < 40) begin
      rise_t[nr] = cyc;
      if (nr >= rx_start) begin
        dout = miso_sr[23];
        miso_sr = {miso_sr[22:0], 1'b0};
      end
      nr = nr + 1;
    end
    if (prev_sclk && !sclk && nf < 40) begin
      fall_t[nf] = cyc;
      mosi[nf/8] = {mosi[nf/8][6:0], din};
      nf = nf + 1;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [1:0] kind, input logic [7:0] op,
                         input logic [3:0] addr, input logic [7:0] wd,
                         input logic [23:0] reply, input logic [31:0] exp_rx);
    int ntx, nrx, nbits, hold, bad_act, bad_exp;
    logic [7:0] exp_b [3];
    string rtag;
    ntx = (kind == 2'd1) ? 3 : (kind == 2'd2) ? 2 : 1;
    nrx = (kind == 2'd2) ? 1 : (kind == 2'd3) ? 3 : 0;
    nbits = 8 * (ntx + nrx);
    exp_b[0] = (kind == 2'd1 || kind == 2'd2) ? {op[7:4], addr} : op;
    exp_b[1] = 8'h00;
    exp_b[2] = wd;
    hold = (op == 8'h03 || op == 8'hFC || op == 8'hFE) ? SH + 24*MD : SH + 4*MD;
    rtag = (kind == 2'd1) ? "R3" : (kind == 2'd2) ? "R4" : (kind == 2'd3) ? "R5" : "R10";
    miso_load = reply;
    rx_start = 8 * ntx;

    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_op = op; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!req_ready && !cs_n, "R9", "busy ready/cs", {req_ready, cs_n}, 2'b00);
    while (!done) @(negedge clk);
    chk(rx_data == exp_rx, rtag, "rx_data", rx_data, exp_rx);
    chk(cs_n && req_ready, "R10", "cs/ready at done", {cs_n, req_ready}, 2'b11);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);

    chk(nf == nbits && nr == nbits, "R1", "sclk pulses", nf, nbits);
    for (int b = 0; b < ntx; b++)
      chk(mosi[b] == exp_b[b], rtag, "tx byte", mosi[b], exp_b[b]);
    chk(rise_t[0] - t_csf == SH, "R9", "cs lead", rise_t[0] - t_csf, SH);

    bad_act = -1; bad_exp = -1;
    for (int i = 0; i < nbits; i++) begin
      if (fall_t[i] - rise_t[i] != SH && bad_exp < 0) begin
        bad_act = fall_t[i] - rise_t[i]; bad_exp = SH;
      end
      if (i % 8 != 7 && i < nbits - 1 && rise_t[i+1] - fall_t[i] != SH && bad_exp < 0) begin
        bad_act = rise_t[i+1] - fall_t[i]; bad_exp = SH;
      end
    end
    chk(bad_exp < 0, "R2", "sclk phase", bad_act, bad_exp);

    for (int i = 7; i < nbits - 1; i += 8) begin
      if (nrx > 0 && i + 1 == 8 * ntx)
        chk(rise_t[i+1] - fall_t[i] == SH + 50*MD, "R6", "readback wait",
            rise_t[i+1] - fall_t[i], SH + 50*MD);
      else
        chk(rise_t[i+1] - fall_t[i] == SH + GP, "R7", "byte gap",
            rise_t[i+1] - fall_t[i], SH + GP);
    end
    chk(t_csr - fall_t[nbits-1] == hold, "R8", "hold-off", t_csr - fall_t[nbits-1], hold);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && req_ready && !done && rx_data == 0, "R9", "reset state",
        {cs_n, sclk, req_ready, done}, 4'b1010);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !sclk, "R1", "idle pins", {cs_n, sclk}, 2'b10);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][77:76], VEC[v][75:68], VEC[v][67:64], VEC[v][63:56],
              VEC[v][55:32], VEC[v][31:0]);

    // reset in the middle of a readback
    miso_load = 24'h123456;
    rx_start = 8;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd3; req_op = 8'h01;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(cs_n && !sclk && req_ready, "R9", "async reset mid-transfer",
        {cs_n, sclk, req_ready}, 3'b101);
    @(negedge clk);
    rst_ni = 1'b1;
    run_vec(2'd3, 8'h01, 4'h0, 8'h00, 24'h123456, 32'h00123456);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule